// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is the register window through which a host processor hands commands to an embedded controller core. The host sees a 32-bit register bus. It programs two pointer registers, stages up to 16 bytes of payload in a write-only buffer, and then writes one packed command word. That write alone starts the transaction. The controller receives a one-cycle doorbell together with the decoded command code, sub-command and payload size. It can read the staged payload word by word, fill a 16-byte response buffer that the host reads back, and finish the transaction with a pass or fail indication and an 8-bit error code.

The status word lets the host poll for completion. It holds busy, error, the latched sub-command id, the initiator id presented with the command, and the error code. A host that prefers interrupts sets the completion-request bit in the command word. The block then returns a single-cycle edge interrupt when that command completes, and the host needs no clearing action. While a command is pending, the fields presented to the controller are frozen, and further command writes are dropped.

Top module: `ipc_mailbox`

## Requirements
- R1: A host write to offset 0x00 while idle is accepted. On the next clock edge busy reads 1, `ctl_doorbell` pulses high for exactly one cycle, and the controller sees the command code from bits [7:0], the sub-command from bits [15:12] and the payload size from bits [23:16]. Bit 8 is the completion-request flag. Bits [11:9] and [31:24] are ignored.
- R2: A command write while busy is dropped. It raises no doorbell, and the command code, sub-command and size outputs keep their values until completion.
- R3: The status word at offset 0x04 reads busy at bit 0, error at bit 1, zero at [3:2], the latched sub-command at [7:4], the latched initiator id at [15:8], the error code at [23:16] and zero at [31:24].
- R4: `ctl_done` while busy clears busy on the next edge. If `ctl_fail` is high at that edge, error is set and `ctl_err_code` is captured; otherwise error and the code read 0. An accepted command also clears error and the code.
- R5: `hst_irq` pulses for exactly one cycle in the cycle after completion, and only when the completed command had bit 8 set.
- R6: Offsets 0x08 (source) and 0x0C (destination) are 32-bit read/write registers whose values drive `ctl_src_ptr` and `ctl_dst_ptr`.
- R7: A host write to offset 0x80+4*i stores a full word in payload slot i. The controller reads slot i on `ctl_wbuf_rdata` when `ctl_wbuf_idx` = i.
- R8: A controller write with `ctl_rbuf_wr` stores `ctl_rbuf_wdata` in response slot `ctl_rbuf_idx`. The host reads slot i at offset 0x90+4*i, and host writes there change nothing.
- R9: Reads of offset 0x00 and of the payload window 0x80-0x8C return 0. Host writes to 0x04 leave the status word unchanged.
- R10: Reset clears busy, error, the error code, the latched fields, both pointers and both buffers, and holds the doorbell and interrupt low.
- R11: `ctl_done` while idle changes no status field and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_wr | input | 1 | Host write strobe |
| hst_addr | input | 8 | Host byte address (word aligned) |
| hst_wdata | input | 32 | Host write data |
| hst_init_id | input | 8 | Initiator id captured with a command |
| hst_rdata | output | 32 | Host read data for `hst_addr` (combinational) |
| hst_irq | output | 1 | Completion interrupt pulse |
| ctl_doorbell | output | 1 | One-cycle new-command pulse to the controller |
| ctl_cmd_code | output | 8 | Latched command code |
| ctl_sub_cmd | output | 4 | Latched sub-command id |
| ctl_size | output | 8 | Latched payload size in bytes |
| ctl_src_ptr | output | 32 | Source pointer register |
| ctl_dst_ptr | output | 32 | Destination pointer register |
| ctl_wbuf_idx | input | 2 | Payload slot selected by the controller |
| ctl_wbuf_rdata | output | 32 | Selected payload word |
| ctl_rbuf_wr | input | 1 | Response buffer write strobe |
| ctl_rbuf_idx | input | 2 | Response slot to write |
| ctl_rbuf_wdata | input | 32 | Response word |
| ctl_done | input | 1 | Controller completion strobe |
| ctl_fail | input | 1 | Completion carries a failure |
| ctl_err_code | input | 8 | Error code sampled with a failing completion |

## Verification
The assertions assume that the controller raises `ctl_done` only as a one-cycle strobe, and that `ctl_fail` and `ctl_err_code` are valid in that same cycle. They also assume that host addresses are word aligned. The stimulus holds every input for whole cycles, changing it just after a rising edge. It pulses `ctl_done` for a single cycle and issues only aligned addresses. It still deliberately sends completions while idle and command writes while busy, including both in the same cycle, so that the ignore paths are exercised.

// File: rtl/ipc_mbx_pkg.sv
package ipc_mbx_pkg;

  localparam int unsigned DATA_W = 32;

  // Host register offsets (byte addresses)
  localparam logic [31:0] OFS_CMD    = 32'h0000_0000;
  localparam logic [31:0] OFS_STATUS = 32'h0000_0004;
  localparam logic [31:0] OFS_SRC    = 32'h0000_0008;
  localparam logic [31:0] OFS_DST    = 32'h0000_000C;
  localparam logic [31:0] OFS_WBUF   = 32'h0000_0080;
  localparam logic [31:0] OFS_RBUF   = 32'h0000_0090;

  // Packed command word, MSB first
  typedef struct packed {
    logic [7:0] rsvd_hi;
    logic [7:0] size;
    logic [3:0] sub;
    logic [2:0] rsvd_lo;
    logic       ioc;
    logic [7:0] code;
  } cmd_word_t;

  // Packed status word, MSB first
  typedef struct packed {
    logic [7:0] rsvd_hi;
    logic [7:0] ecode;
    logic [7:0] init_id;
    logic [3:0] cmd_id;
    logic [1:0] rsvd_lo;
    logic       err;
    logic       busy;
  } status_word_t;

endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  // Assertion is asynchronous, release waits for two rising edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/mbx_wordbuf.sv
module mbx_wordbuf #(
  parameter int unsigned WORDS = 4,
  parameter int unsigned DW    = 32,
  localparam int unsigned IW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IW-1:0]       wr_idx,
  input  logic [DW-1:0]       wr_data,
  output logic [WORDS*DW-1:0] words_o
);

  logic [WORDS-1:0] word_en;

  for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
    logic [DW-1:0] word_q;
    logic [DW-1:0] word_d;

    // Next-state: a slot loads only when addressed
    always_comb begin
      word_en[gi] = wr_en && (wr_idx == IW'(gi));
      word_d      = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (word_en[gi]) begin
        word_q <= word_d;
      end
    end

    assign words_o[gi*DW +: DW] = word_q;
  end

  AST_WORD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (words_o[$past(wr_idx)*DW +: DW] == $past(wr_data))); // R7

  AST_SLOT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(word_en)); // R8

endmodule

// File: rtl/mbx_cmd_ctrl.sv
module mbx_cmd_ctrl
  import ipc_mbx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  cmd_word_t  cmd_word,
  input  logic [7:0] init_id,
  input  logic       done,
  input  logic       fail,
  input  logic [7:0] err_code,
  output logic       busy,
  output logic       err,
  output logic [7:0] ecode,
  output logic [7:0] init_q,
  output logic [7:0] code,
  output logic [3:0] sub,
  output logic [7:0] size,
  output logic       doorbell,
  output logic       irq
);

  logic       busy_q, busy_d;
  logic       err_q, err_d;
  logic [7:0] ecode_q, ecode_d;
  logic [7:0] init_qq;
  logic [7:0] code_q;
  logic [3:0] sub_q;
  logic [7:0] size_q;
  logic       ioc_q;
  logic       db_q, db_d;
  logic       irq_q, irq_d;
  logic       accept, finish;
  logic       fld_en, err_en;
  logic       unused_rsvd;

  assign unused_rsvd = ^{cmd_word.rsvd_hi, cmd_word.rsvd_lo};

  // Next-state logic
  always_comb begin
    accept  = cmd_wr && !busy_q;
    finish  = done && busy_q;
    fld_en  = accept;
    err_en  = accept || finish;

    busy_d  = busy_q;
    if (finish) begin
      busy_d = 1'b0;
    end else if (accept) begin
      busy_d = 1'b1;
    end

    err_d   = finish ? fail : 1'b0;
    ecode_d = (finish && fail) ? err_code : 8'h00;
    db_d    = accept;
    irq_d   = finish && ioc_q;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      db_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      db_q   <= db_d;
      irq_q  <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      ecode_q <= 8'h00;
    end else if (err_en) begin
      err_q   <= err_d;
      ecode_q <= ecode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= 8'h00;
      sub_q   <= 4'h0;
      size_q  <= 8'h00;
      ioc_q   <= 1'b0;
      init_qq <= 8'h00;
    end else if (fld_en) begin
      code_q  <= cmd_word.code;
      sub_q   <= cmd_word.sub;
      size_q  <= cmd_word.size;
      ioc_q   <= cmd_word.ioc;
      init_qq <= init_id;
    end
  end

  assign busy     = busy_q;
  assign err      = err_q;
  assign ecode    = ecode_q;
  assign init_q   = init_qq;
  assign code     = code_q;
  assign sub      = sub_q;
  assign size     = size_q;
  assign doorbell = db_q;
  assign irq      = irq_q;

  AST_ACCEPT_RINGS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy) |=> (doorbell && busy)); // R1

  AST_DOORBELL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |=> !doorbell); // R1

  AST_BUSY_WR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr && !done) |=> !doorbell); // R2

  AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ($stable(code) && $stable(sub) && $stable(size))); // R2

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done) |=> (!busy && (err == $past(fail)))); // R4

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R5

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(busy) && !busy)); // R5

  AST_IDLE_DONE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && done && !cmd_wr) |=> ($stable(err) && $stable(ecode) && !irq)); // R11

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mbx_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BUF_WORDS = 4,
  localparam int unsigned IW       = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_wr,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [31:0]       hst_wdata,
  input  logic [7:0]        hst_init_id,
  output logic [31:0]       hst_rdata,
  output logic              hst_irq,
  output logic              ctl_doorbell,
  output logic [7:0]        ctl_cmd_code,
  output logic [3:0]        ctl_sub_cmd,
  output logic [7:0]        ctl_size,
  output logic [31:0]       ctl_src_ptr,
  output logic [31:0]       ctl_dst_ptr,
  input  logic [IW-1:0]     ctl_wbuf_idx,
  output logic [31:0]       ctl_wbuf_rdata,
  input  logic              ctl_rbuf_wr,
  input  logic [IW-1:0]     ctl_rbuf_idx,
  input  logic [31:0]       ctl_rbuf_wdata,
  input  logic              ctl_done,
  input  logic              ctl_fail,
  input  logic [7:0]        ctl_err_code
);

  localparam int unsigned RGN_LSB = IW + 2;

  logic srst_n;

  // Address decode
  logic          aligned;
  logic          hit_cmd, hit_sts, hit_src, hit_dst, hit_wbuf, hit_rbuf;
  logic [IW-1:0] slot;
  logic          cmd_wr, ptr_wr, wbuf_wr;
  logic [IW-1:0] ptr_idx;

  // Internal state views
  logic                  busy, err;
  logic [7:0]            ecode, init_q;
  logic [2*DATA_W-1:0]   ptr_words;
  logic [BUF_WORDS*DATA_W-1:0] wbuf_words, rbuf_words;
  status_word_t          sts;

  mbx_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  always_comb begin
    aligned  = (hst_addr[1:0] == 2'b00);
    hit_cmd  = aligned && (hst_addr == OFS_CMD[ADDR_W-1:0]);
    hit_sts  = aligned && (hst_addr == OFS_STATUS[ADDR_W-1:0]);
    hit_src  = aligned && (hst_addr == OFS_SRC[ADDR_W-1:0]);
    hit_dst  = aligned && (hst_addr == OFS_DST[ADDR_W-1:0]);
    hit_wbuf = aligned && (hst_addr[ADDR_W-1:RGN_LSB] == OFS_WBUF[ADDR_W-1:RGN_LSB]);
    hit_rbuf = aligned && (hst_addr[ADDR_W-1:RGN_LSB] == OFS_RBUF[ADDR_W-1:RGN_LSB]);
    slot     = hst_addr[RGN_LSB-1:2];

    cmd_wr   = hst_wr && hit_cmd;
    ptr_wr   = hst_wr && (hit_src || hit_dst);
    ptr_idx  = hit_dst ? IW'(1) : IW'(0);
    wbuf_wr  = hst_wr && hit_wbuf;
  end

  mbx_cmd_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (srst_n),
    .cmd_wr   (cmd_wr),
    .cmd_word (cmd_word_t'(hst_wdata)),
    .init_id  (hst_init_id),
    .done     (ctl_done),
    .fail     (ctl_fail),
    .err_code (ctl_err_code),
    .busy     (busy),
    .err      (err),
    .ecode    (ecode),
    .init_q   (init_q),
    .code     (ctl_cmd_code),
    .sub      (ctl_sub_cmd),
    .size     (ctl_size),
    .doorbell (ctl_doorbell),
    .irq      (hst_irq)
  );

  mbx_wordbuf #(.WORDS(2), .DW(DATA_W)) u_ptrs (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_en   (ptr_wr),
    .wr_idx  (ptr_idx[0:0]),
    .wr_data (hst_wdata),
    .words_o (ptr_words)
  );

  mbx_wordbuf #(.WORDS(BUF_WORDS), .DW(DATA_W)) u_wbuf (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_en   (wbuf_wr),
    .wr_idx  (slot),
    .wr_data (hst_wdata),
    .words_o (wbuf_words)
  );

  mbx_wordbuf #(.WORDS(BUF_WORDS), .DW(DATA_W)) u_rbuf (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_en   (ctl_rbuf_wr),
    .wr_idx  (ctl_rbuf_idx),
    .wr_data (ctl_rbuf_wdata),
    .words_o (rbuf_words)
  );

  assign ctl_src_ptr    = ptr_words[0 +: DATA_W];
  assign ctl_dst_ptr    = ptr_words[DATA_W +: DATA_W];
  assign ctl_wbuf_rdata = wbuf_words[ctl_wbuf_idx*DATA_W +: DATA_W];

  // Host read mux: write-only locations and unmapped space read zero
  always_comb begin
    sts         = '0;
    sts.busy    = busy;
    sts.err     = err;
    sts.cmd_id  = ctl_sub_cmd;
    sts.init_id = init_q;
    sts.ecode   = ecode;

    hst_rdata = '0;
    if (hit_sts) begin
      hst_rdata = sts;
    end else if (hit_src) begin
      hst_rdata = ctl_src_ptr;
    end else if (hit_dst) begin
      hst_rdata = ctl_dst_ptr;
    end else if (hit_rbuf) begin
      hst_rdata = rbuf_words[slot*DATA_W +: DATA_W];
    end
  end

  AST_CMD_READS_ZERO: assert property (@(posedge clk) disable iff (!srst_n)
    hit_cmd |-> (hst_rdata == 32'h0)); // R9

  AST_ERR_CODE_CLEAN: assert property (@(posedge clk) disable iff (!srst_n)
    !err |-> (ecode == 8'h00)); // R4

endmodule

// File: tb/sim_ipc_mailbox.sv
module sim_ipc_mailbox;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hst_wr;
  logic [7:0]  hst_addr;
  logic [31:0] hst_wdata;
  logic [7:0]  hst_init_id;
  logic [31:0] hst_rdata;
  logic        hst_irq;
  logic        ctl_doorbell;
  logic [7:0]  ctl_cmd_code;
  logic [3:0]  ctl_sub_cmd;
  logic [7:0]  ctl_size;
  logic [31:0] ctl_src_ptr, ctl_dst_ptr;
  logic [1:0]  ctl_wbuf_idx;
  logic [31:0] ctl_wbuf_rdata;
  logic        ctl_rbuf_wr;
  logic [1:0]  ctl_rbuf_idx;
  logic [31:0] ctl_rbuf_wdata;
  logic        ctl_done, ctl_fail;
  logic [7:0]  ctl_err_code;

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;
  bit ended  = 1'b0;

  always #5 clk = ~clk;

  ipc_mailbox u0 (
    .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_init_id(hst_init_id), .hst_rdata(hst_rdata),
    .hst_irq(hst_irq), .ctl_doorbell(ctl_doorbell), .ctl_cmd_code(ctl_cmd_code),
    .ctl_sub_cmd(ctl_sub_cmd), .ctl_size(ctl_size), .ctl_src_ptr(ctl_src_ptr),
    .ctl_dst_ptr(ctl_dst_ptr), .ctl_wbuf_idx(ctl_wbuf_idx),
    .ctl_wbuf_rdata(ctl_wbuf_rdata), .ctl_rbuf_wr(ctl_rbuf_wr),
    .ctl_rbuf_idx(ctl_rbuf_idx), .ctl_rbuf_wdata(ctl_rbuf_wdata),
    .ctl_done(ctl_done), .ctl_fail(ctl_fail), .ctl_err_code(ctl_err_code)
  );

  // Behavioural reference model
  int m_busy, m_err, m_ecode, m_init, m_code, m_sub, m_size, m_ioc;
  int m_db, m_irq, m_src, m_dst;
  int m_wbuf[4];
  int m_rbuf[4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_err = 0; m_ecode = 0; m_init = 0; m_code = 0;
      m_sub = 0; m_size = 0; m_ioc = 0; m_db = 0; m_irq = 0;
      m_src = 0; m_dst = 0;
      for (int i = 0; i < 4; i++) begin
        m_wbuf[i] = 0;
        m_rbuf[i] = 0;
      end
    end else begin
      int acc, fin;
      acc = (hst_wr && hst_addr == 8'h00 && m_busy == 0) ? 1 : 0;
      fin = (ctl_done && m_busy == 1) ? 1 : 0;
      m_db  = acc;
      m_irq = (fin == 1 && m_ioc == 1) ? 1 : 0;
      if (fin == 1) begin
        m_busy  = 0;
        m_err   = ctl_fail ? 1 : 0;
        m_ecode = ctl_fail ? int'(ctl_err_code) : 0;
      end else if (acc == 1) begin
        m_busy  = 1; m_err = 0; m_ecode = 0;
        m_code  = int'(hst_wdata[7:0]);
        m_ioc   = int'(hst_wdata[8]);
        m_sub   = int'(hst_wdata[15:12]);
        m_size  = int'(hst_wdata[23:16]);
        m_init  = int'(hst_init_id);
      end
      if (hst_wr && hst_addr == 8'h08) m_src = int'(hst_wdata);
      if (hst_wr && hst_addr == 8'h0C) m_dst = int'(hst_wdata);
      if (hst_wr && hst_addr >= 8'h80 && hst_addr <= 8'h8C)
        m_wbuf[(hst_addr - 8'h80) >> 2] = int'(hst_wdata);
      if (ctl_rbuf_wr) m_rbuf[ctl_rbuf_idx] = int'(ctl_rbuf_wdata);
    end
  end

  function automatic logic [31:0] exp_read(logic [7:0] a);
    case (a)
      8'h04: exp_read = {8'h00, 8'(m_ecode), 8'(m_init), 4'(m_sub), 2'b00,
                         1'(m_err), 1'(m_busy)};
      8'h08: exp_read = 32'(m_src);
      8'h0C: exp_read = 32'(m_dst);
      8'h90, 8'h94, 8'h98, 8'h9C: exp_read = 32'(m_rbuf[(a - 8'h90) >> 2]);
      default: exp_read = 32'h0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model on every clock, mid-cycle
  always @(negedge clk) begin
    if (cmp_on && !ended) begin
      check("R1 doorbell", 32'(ctl_doorbell), 32'(m_db));
      check("R5 irq", 32'(hst_irq), 32'(m_irq));
      check("R1 R2 code", 32'(ctl_cmd_code), 32'(m_code));
      check("R1 R2 sub", 32'(ctl_sub_cmd), 32'(m_sub));
      check("R1 R2 size", 32'(ctl_size), 32'(m_size));
      check("R6 src", ctl_src_ptr, 32'(m_src));
      check("R6 dst", ctl_dst_ptr, 32'(m_dst));
      check("R7 wbuf", ctl_wbuf_rdata, 32'(m_wbuf[ctl_wbuf_idx]));
      check("R3 R8 R9 rdata", hst_rdata, exp_read(hst_addr));
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic hwrite(logic [7:0] a, logic [31:0] d);
    hst_addr = a; hst_wdata = d; hst_wr = 1'b1;
    step();
    hst_wr = 1'b0;
  endtask

  task automatic hread(logic [7:0] a, string tag, logic [31:0] exp);
    hst_addr = a;
    #1;
    check(tag, hst_rdata, exp);
  endtask

  task automatic complete(logic f, logic [7:0] c);
    ctl_done = 1'b1; ctl_fail = f; ctl_err_code = c;
    step();
    ctl_done = 1'b0; ctl_fail = 1'b0; ctl_err_code = 8'h00;
  endtask

  task automatic finish_run();
    ended = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; hst_wr = 1'b0; hst_addr = 8'h00; hst_wdata = '0;
    hst_init_id = 8'h00; ctl_wbuf_idx = 2'd0; ctl_rbuf_wr = 1'b0;
    ctl_rbuf_idx = 2'd0; ctl_rbuf_wdata = '0; ctl_done = 1'b0;
    ctl_fail = 1'b0; ctl_err_code = 8'h00;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    cmp_on = 1'b1;

    // R10: reset state
    hread(8'h04, "R10 status after reset", 32'h0000_0000);
    check("R10 doorbell after reset", 32'(ctl_doorbell), 32'h0);

    // R6: pointer registers
    hwrite(8'h08, 32'hA5A5_0001);
    hwrite(8'h0C, 32'h5A5A_0002);
    check("R6 src out", ctl_src_ptr, 32'hA5A5_0001);
    hread(8'h0C, "R6 dst readback", 32'h5A5A_0002);

    // R7: payload words
    for (int i = 0; i < 4; i++) hwrite(8'h80 + 8'(4 * i), 32'h1000_0000 + 32'(i * 17));
    ctl_wbuf_idx = 2'd2;
    #1 check("R7 slot 2", ctl_wbuf_rdata, 32'h1000_0022);
    hread(8'h84, "R9 payload reads zero", 32'h0);

    // R1: accepted command, code 3C ioc 1 sub 5 size 0C
    hst_init_id = 8'h42;
    hwrite(8'h00, 32'hFF0C_5F3C);
    check("R1 doorbell high", 32'(ctl_doorbell), 32'h1);
    check("R1 code", 32'(ctl_cmd_code), 32'h3C);
    check("R1 size", 32'(ctl_size), 32'h0C);
    hread(8'h04, "R3 status busy", 32'h0000_4251);
    step();
    check("R1 doorbell single pulse", 32'(ctl_doorbell), 32'h0);

    // R2: command while busy is dropped
    hst_init_id = 8'h99;
    hwrite(8'h00, 32'h0003_2011);
    check("R2 no doorbell", 32'(ctl_doorbell), 32'h0);
    check("R2 sub held", 32'(ctl_sub_cmd), 32'h5);

    // R8: response buffer
    for (int i = 0; i < 4; i++) begin
      ctl_rbuf_wr = 1'b1; ctl_rbuf_idx = 2'(i); ctl_rbuf_wdata = 32'hBEEF_0000 + 32'(i);
      step();
    end
    ctl_rbuf_wr = 1'b0;
    hwrite(8'h98, 32'hDEAD_DEAD);
    hread(8'h98, "R8 host write ignored", 32'hBEEF_0002);

    // R4 R5: successful completion with interrupt request
    complete(1'b0, 8'h77);
    check("R5 irq pulse", 32'(hst_irq), 32'h1);
    hread(8'h04, "R4 status after pass", 32'h0000_4250);
    step();
    check("R5 irq one cycle", 32'(hst_irq), 32'h0);

    // R4: failing completion, no interrupt requested
    hst_init_id = 8'h07;
    hwrite(8'h00, 32'h0004_2011);
    step();
    complete(1'b1, 8'h5E);
    check("R5 no irq without request", 32'(hst_irq), 32'h0);
    hread(8'h04, "R4 status after fail", 32'h005E_0722);

    // R11: completion while idle
    complete(1'b0, 8'h00);
    hread(8'h04, "R11 idle done ignored", 32'h005E_0722);
    check("R11 no irq", 32'(hst_irq), 32'h0);

    // R9: status not writable, command reads zero
    hwrite(8'h04, 32'hFFFF_FFFF);
    hread(8'h04, "R9 status write ignored", 32'h005E_0722);
    hread(8'h00, "R9 command reads zero", 32'h0);

    // R4: new command clears the error
    hst_init_id = 8'h01;
    hwrite(8'h00, 32'h0000_0101);
    hread(8'h04, "R4 error cleared", 32'h0000_0101);

    // R2 R4: write and completion in the same cycle; completion wins
    hst_addr = 8'h00; hst_wdata = 32'h0000_3122; hst_wr = 1'b1; ctl_done = 1'b1;
    step();
    hst_wr = 1'b0; ctl_done = 1'b0;
    check("R2 no doorbell on collide", 32'(ctl_doorbell), 32'h0);
    check("R5 irq on collide", 32'(hst_irq), 32'h1);
    hread(8'h04, "R4 idle after collide", 32'h0000_0100);

    // R10: reset in the middle of a command
    hwrite(8'h00, 32'h0010_7155);
    rst_n = 1'b0;
    #1;
    hread(8'h04, "R10 status cleared", 32'h0);
    hread(8'h94, "R10 rbuf cleared", 32'h0);
    check("R10 src cleared", ctl_src_ptr, 32'h0);
    check("R10 code cleared", 32'(ctl_cmd_code), 32'h0);
    step();
    rst_n = 1'b1;
    repeat (4) step();
    hread(8'h08, "R10 src after release", 32'h0);

    finish_run();
  end

endmodule